// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

A first-in first-out buffer, 9 bits wide and 2048 words deep, with a write clock and a read clock. The two clocks may be unrelated or may be the same net. Four active-low flags report the fill level. Full and almost-full belong to the write side. Empty and almost-empty belong to the read side. Each pointer crosses into the other domain as Gray code through a two-flop synchronizer. A flag therefore asserts on the edge that causes it, but it releases only after the other side's pointer has been synchronized.

One write-side pin has two roles, and its level while reset is low chooses which one it takes. If the pin is high during reset, it acts as a second write enable. If it is low during reset, it acts as a load strobe. While the strobe is low, the write enable steps through the two 11-bit offset registers a byte at a time. With the strobe low and both read enables low, the read side returns the offsets in the same rotating order. A FIFO read needs both read enables low. The output register holds its value on every cycle without a read. An output-enable input blanks the data port and clears a valid indication; the port is not tri-stated.

Top module: `prog_flag_fifo`

## Requirements
- R1: While reset is low, both pointers clear and the output register clears to zero. Both offsets return to 7. Afterwards `full_n`=1, `afull_n`=1, `empty_n`=0 and `aempty_n`=0.
- R2: The level of `wen2_ld` at rising write/read clock edges while `rst_n` is low sets the mode until the next reset: 1 selects second-enable mode and 0 selects load mode. In load mode, `wen1_n`=0 with `wen2_ld`=0 never stores a FIFO word.
- R3: A word is stored on a rising `wclk` only when `wen1_n`=0, `wen2_ld`=1 and `full_n`=1. In every other case nothing is stored.
- R4: In load mode, each `wclk` edge with `wen1_n`=0 and `wen2_ld`=0 writes the next offset step. The order is empty-offset bits [7:0] from `din[7:0]`, then empty-offset bits [10:8] from `din[2:0]`, then full-offset bits [7:0], then full-offset bits [10:8]. After the fourth step the order wraps to the first.
- R5: In load mode, each `rclk` edge with `wen2_ld`=0 and both read enables low loads the next offset step into the output register. The steps follow the R4 order. The selected bits are zero-extended into `dout`, and the order wraps after four steps.
- R6: A FIFO read happens on a rising `rclk` only when `ren1_n`=0, `ren2_n`=0 and `empty_n`=1. In load mode it also requires `wen2_ld`=1. Without a read or offset step, `dout` holds its value.
- R7: Words leave in the order they were stored, with no loss or duplication, including when a write and a read share a clock edge.
- R8: `full_n` goes low on the write edge that stores the 2048th word. A write attempted while full stores nothing.
- R9: While `empty_n` is low, FIFO reads are ignored and `dout` holds its value.
- R10: `aempty_n` is low whenever the read side's word count is at or below the empty offset.
- R11: `afull_n` is low whenever the write side's free space is at or below the full offset.
- R12: With `oe_n`=1, `dout` is all zeros and `dout_vld`=0. With `oe_n`=0, `dout` shows the output register and `dout_vld`=1.
- R13: A flag asserts on the edge that causes it. `empty_n` rises on the third `rclk` edge after the write edge. `full_n` rises on the third `wclk` edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low; also the mode capture window |
| din | input | 9 | Write data; also the offset byte in load mode |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Second write enable (active high) or load strobe (active low), by mode |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data, zero while disabled |
| dout_vld | output | 1 | High when `dout` is driven from the output register |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
A store and a fetch can land on the same clock edge. The sharpest case is when the buffer holds a single word or has just drained, because there the empty flag's release latency decides whether the read is taken. The bench makes this happen by driving both enables low in the same cycle for a run of cycles, starting from an empty buffer. A scoreboard queue holds every word the write driver expects to be stored. A monitor pops that queue on each read that the flags allow and compares it with `dout`. Any dropped, duplicated or reordered word shows up as a mismatch or as a leftover entry in the queue.

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int DW          = 9,
  parameter int AW          = 11,
  parameter int OW          = 11,
  parameter int OFS_DEFAULT = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int LO_W  = 8;
  localparam int HI_W  = OW - LO_W;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [OW-1:0] ae_ofs, af_ofs;

  // write domain
  logic          wr_ld;
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic [1:0]    wsel;

  always_ff @(posedge wclk)
    if (!rst_n) wr_ld <= !wen2_ld;

  wire           wr_fifo = rst_n && !wen1_n && wen2_ld && full_n;
  wire           ofs_wr  = rst_n && wr_ld && !wen1_n && !wen2_ld;
  wire  [PW-1:0] wbin_nx = wbin + PW'(wr_fifo);
  wire  [PW-1:0] wcnt_nx = wbin_nx - g2b(rg_s2);
  wire  [PW-1:0] wfree   = PW'(DEPTH) - wcnt_nx;

  always_ff @(posedge wclk)
    if (wr_fifo) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= b2g(wbin_nx);
      rg_s1   <= rgray;
      rg_s2   <= rg_s1;
      full_n  <= wcnt_nx != PW'(DEPTH);
      afull_n <= wfree > PW'(af_ofs);
    end

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      ae_ofs <= OW'(OFS_DEFAULT);
      af_ofs <= OW'(OFS_DEFAULT);
      wsel   <= '0;
    end else if (ofs_wr) begin
      case (wsel)
        2'd0: ae_ofs[LO_W-1:0]  <= din[LO_W-1:0];
        2'd1: ae_ofs[OW-1:LO_W] <= din[HI_W-1:0];
        2'd2: af_ofs[LO_W-1:0]  <= din[LO_W-1:0];
        2'd3: af_ofs[OW-1:LO_W] <= din[HI_W-1:0];
      endcase
      wsel <= wsel + 2'd1;
    end

  // read domain
  logic          rd_ld;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic [1:0]    rsel;
  logic [DW-1:0] dout_q;

  always_ff @(posedge rclk)
    if (!rst_n) rd_ld <= !wen2_ld;

  wire           ld_low  = rd_ld && !wen2_ld;
  wire           both_rd = !ren1_n && !ren2_n;
  wire           rd_fifo = rst_n && both_rd && empty_n && !ld_low;
  wire           ofs_rd  = rst_n && both_rd && ld_low;
  wire  [PW-1:0] rbin_nx = rbin + PW'(rd_fifo);
  wire  [PW-1:0] rcnt_nx = g2b(wg_s2) - rbin_nx;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wg_s1    <= '0;
      wg_s2    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= b2g(rbin_nx);
      wg_s1    <= wgray;
      wg_s2    <= wg_s1;
      empty_n  <= rcnt_nx != '0;
      aempty_n <= rcnt_nx > PW'(ae_ofs);
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      dout_q <= '0;
      rsel   <= '0;
    end else if (rd_fifo) begin
      dout_q <= mem[rbin[AW-1:0]];
    end else if (ofs_rd) begin
      case (rsel)
        2'd0: dout_q <= DW'(ae_ofs[LO_W-1:0]);
        2'd1: dout_q <= DW'(ae_ofs[OW-1:LO_W]);
        2'd2: dout_q <= DW'(af_ofs[LO_W-1:0]);
        2'd3: dout_q <= DW'(af_ofs[OW-1:LO_W]);
      endcase
      rsel <= rsel + 2'd1;
    end

  assign dout     = oe_n ? '0 : dout_q;
  assign dout_vld = !oe_n;

endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
  parameter int DW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wen2_ld,
  input logic          ren1_n,
  input logic          ren2_n,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          rd_ld
);

  a_r6_hold_without_both: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) && !oe_n |=> oe_n || $stable(dout));

  a_r9_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n && !oe_n && !(rd_ld && !wen2_ld) |=> oe_n || $stable(dout));

  a_r10_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  a_r11_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);

endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen2_ld(wen2_ld),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .dout(dout),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n),
  .aempty_n(aempty_n), .rd_ld(rd_ld)
);

// File: tb/prog_flag_fifo_tb.sv
`timescale 1ns/1ps
module prog_flag_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] din = '0;
  logic       wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic [8:0] dout;
  logic       dout_vld, full_n, afull_n, empty_n, aempty_n;

  int total = 0, bad = 0, cyc = 0;
  logic [8:0] exp_q[$];
  bit tb_ld = 1'b0;
  bit fired = 1'b0;

  always #2.5 clk = ~clk;

  prog_flag_fifo u_dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .dout(dout), .dout_vld(dout_vld), .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: a FIFO read per R6 took place on this edge
  always @(posedge clk)
    fired <= rst_n && !ren1_n && !ren2_n && empty_n && !(tb_ld && !wen2_ld);

  always @(negedge clk) begin
    logic [8:0] e;
    if (fired) begin
      if (exp_q.size() == 0) chk("R7 read with nothing expected", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R7 order", int'(dout), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(int n = 1);
    repeat (n) begin
      @(negedge clk);
      wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    end
  endtask

  task automatic wr(logic [8:0] d);
    @(negedge clk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    wen1_n = 1'b0; din = d;
    if (full_n && wen2_ld) exp_q.push_back(d);
  endtask

  task automatic rd();
    @(negedge clk);
    wen1_n = 1'b1;
    ren1_n = 1'b0; ren2_n = 1'b0;
  endtask

  task automatic rw(logic [8:0] d);
    @(negedge clk);
    wen1_n = 1'b0; din = d;
    if (full_n && wen2_ld) exp_q.push_back(d);
    ren1_n = 1'b0; ren2_n = 1'b0;
  endtask

  task automatic do_reset(bit ld);
    @(negedge clk);
    rst_n = 1'b0; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    wen2_ld = !ld; tb_ld = ld;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
  endtask

  task automatic ofs_step_wr(logic [8:0] d);
    @(negedge clk);
    wen1_n = 1'b0; din = d;
    @(negedge clk);
    wen1_n = 1'b1;
  endtask

  task automatic ofs_step_rd(int exp, string req);
    @(negedge clk);
    ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge clk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    chk(req, int'(dout), exp);
  endtask

  initial begin
    int k;
    logic [8:0] rec;

    // second-enable mode
    do_reset(1'b0);
    idle(1);
    chk("R1 full_n", full_n, 1);
    chk("R1 afull_n", afull_n, 1);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 dout", int'(dout), 0);
    chk("R12 dout_vld", dout_vld, 1);

    // R3: enables not both active
    @(negedge clk); wen1_n = 1'b0; wen2_ld = 1'b0; din = 9'h1AB;
    @(negedge clk); wen1_n = 1'b1; wen2_ld = 1'b1;
    idle(6);
    chk("R3 no store", empty_n, 0);

    // R13 empty release latency
    wr(9'h011);
    idle(1);
    k = 0;
    while (!empty_n && k < 20) begin @(negedge clk); k++; end
    chk("R13 empty release edges", k, 3);

    // R10 almost-empty
    for (int i = 0; i < 4; i++) wr(9'h020 + 9'(i));
    idle(6);
    chk("R10 ae at 5", aempty_n, 0);
    chk("R10 not empty", empty_n, 1);
    for (int i = 0; i < 3; i++) wr(9'h030 + 9'(i));
    idle(6);
    chk("R10 ae released at 8", aempty_n, 1);

    // R6 single enable holds
    rd(); idle(1);
    rec = dout;
    @(negedge clk); ren1_n = 1'b0; ren2_n = 1'b1;
    @(negedge clk); ren1_n = 1'b1; ren2_n = 1'b0;
    idle(1);
    chk("R6 hold", int'(dout), int'(rec));

    // R12 output enable
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    chk("R12 blank dout", int'(dout), 0);
    chk("R12 vld low", dout_vld, 0);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R12 restored", int'(dout), int'(rec));

    repeat (7) rd();
    idle(3);
    chk("R7 drained", exp_q.size(), 0);

    // R9 read while empty
    rec = dout;
    rd(); rd(); idle(2);
    chk("R9 hold when empty", int'(dout), int'(rec));

    // R7 simultaneous write and read
    for (int i = 0; i < 30; i++) rw(9'h100 + 9'(i * 7));
    idle(1);
    for (int i = 0; i < 40; i++) rd();
    idle(4);
    chk("R7 overlap drained", exp_q.size(), 0);
    chk("R7 overlap empty", empty_n, 0);

    // R8 / R11 fill
    for (int i = 0; i < 2040; i++) wr(9'(i * 3 + 1));
    idle(1);
    chk("R11 af high at free 8", afull_n, 1);
    wr(9'h0F0);
    idle(1);
    chk("R11 af low at free 7", afull_n, 0);
    for (int i = 0; i < 6; i++) wr(9'h0E0 + 9'(i));
    idle(1);
    chk("R8 not full at 2047", full_n, 1);
    wr(9'h0D0);
    idle(1);
    chk("R8 full", full_n, 0);
    wr(9'h1EE);
    idle(1);
    rd(); idle(1);
    k = 0;
    while (!full_n && k < 20) begin @(negedge clk); k++; end
    chk("R13 full release edges", k, 3);
    repeat (2047) rd();
    idle(4);
    chk("R8 all words out", exp_q.size(), 0);
    chk("R8 extra word absent", empty_n, 0);

    // load mode
    do_reset(1'b1);
    idle(1);
    ofs_step_rd(7, "R5 default ae lo");
    ofs_step_rd(0, "R5 default ae hi");
    ofs_step_rd(7, "R5 default af lo");
    ofs_step_rd(0, "R5 default af hi");
    ofs_step_wr(9'h105);
    ofs_step_wr(9'h1F9);
    ofs_step_wr(9'h003);
    ofs_step_wr(9'h0FA);
    idle(5);
    chk("R2 load strobe stores nothing", empty_n, 0);
    ofs_step_rd(9'h05, "R4 ae lo");
    ofs_step_rd(9'h01, "R4 ae hi");
    ofs_step_rd(9'h03, "R4 af lo");
    ofs_step_rd(9'h02, "R4 af hi");
    ofs_step_rd(9'h05, "R5 wrap");

    @(negedge clk); wen2_ld = 1'b1;
    for (int i = 0; i < 261; i++) wr(9'(i + 5));
    idle(6);
    chk("R10 ae at 261", aempty_n, 0);
    chk("R10 not empty in load mode", empty_n, 1);
    wr(9'h1C3);
    idle(6);
    chk("R10 ae released at 262", aempty_n, 1);
    chk("R11 af high far from full", afull_n, 1);
    repeat (262) rd();
    idle(4);
    chk("R7 load-mode drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule